// File: doc/BRIEF.md
# Equalizer Boost Search Controller

This block selects the receive equalizer setting that gives the widest eye. It holds an ordered, rewritable table of 32 multi-stage boost codes. When started, it walks the table in increasing index order. For each entry it drives the code to the equalizer and asks an external detector for phase lock. When lock is reported, it asks an external eye monitor for horizontal and vertical openings, and it turns them into a figure of merit (FOM).

The controller keeps the best FOM seen so far. After the quality stops improving, it tries a programmable number of further entries before it gives up. It then drives the best code back to the equalizer and latches that code in a result register. A start-index override lets the search begin part way into the table. A soft reset puts the table back to its built-in defaults.

Top module: `eqz_boost_adapt`

## Requirements
- R1: After power-on reset, entry i of the table reads back on `tbl_rd_data` with its default code, for example entry 0 = 0x00, entry 1 = 0x01, entry 2 = 0x04, entry 16 = 0x88 and entry 31 = 0xA5. Each entry packs four 2-bit stage controls: stage 0 in bits 7:6, stage 1 in 5:4, stage 2 in 3:2 and stage 3 in 1:0.
- R2: A cycle with `soft_rst` high returns every table entry to its default code. A table write made in the same cycle is overridden.
- R3: A write through `tbl_wr_en` changes the entry from the next cycle on. The next search uses the new content.
- R4: A `start` pulse while idle raises `busy` on the following cycle. The first candidate is index `start_ovr_idx` when `start_ovr_en` is 1, and index 0 otherwise.
- R5: For each candidate, `eq_code` is loaded with the entry and `lock_req` is raised, with a low cycle before each new request. `eye_req` is raised only after a `lock_ack` that carries `lock_ok` = 1.
- R6: The FOM is `eye_h + eye_v`. A locked candidate whose FOM is strictly greater than the best so far, or that is the first locked candidate, becomes the new best and clears the miss count.
- R7: Every other candidate, including one that fails to lock, adds one to the miss count. The search stops when the miss count exceeds the look-beyond value.
- R8: The look-beyond value is a 4-bit register with reset value 2. It is written through `lb_wr_en` / `lb_wr_data`.
- R9: The search also stops after the candidate at index 31, whatever the miss count.
- R10: When the search stops, `busy` falls and `done` rises on the same edge. From that edge, `eq_code` and `best_code` both hold the best code, and they stay there until the next start.
- R11: If no candidate locked, `fail` is 1 and `eq_code` / `best_code` hold the code of the starting entry. Otherwise `fail` is 0.
- R12: `eq_code` does not change while `lock_req` or `eye_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| soft_rst | input | 1 | Restores the table defaults |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | 5 | Table write index |
| tbl_wr_data | input | 8 | Table write code |
| tbl_rd_idx | input | 5 | Table read index |
| tbl_rd_data | output | 8 | Table read code (combinational) |
| lb_wr_en | input | 1 | Look-beyond register write strobe |
| lb_wr_data | input | 4 | Look-beyond value to write |
| start_ovr_en | input | 1 | Use the start index override |
| start_ovr_idx | input | 5 | Override start index |
| start | input | 1 | Start pulse (ignored while busy) |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished, result valid |
| fail | output | 1 | No candidate achieved lock |
| eq_code | output | 8 | Code driven to the equalizer |
| best_code | output | 8 | Latched winning code |
| lock_req | output | 1 | Phase-lock attempt request |
| lock_ack | input | 1 | Lock attempt finished |
| lock_ok | input | 1 | Lock attempt succeeded (valid with lock_ack) |
| eye_req | output | 1 | Eye measurement request |
| eye_ack | input | 1 | Eye measurement finished |
| eye_h | input | 6 | Horizontal opening (valid with eye_ack) |
| eye_v | input | 6 | Vertical opening (valid with eye_ack) |

## Verification
A wrong best-FOM register or miss count does not show as a bad value on any single cycle. It shows as the wrong number of `lock_req` rising edges in the run, and as a wrong `best_code` when `done` rises. A few tens of cycles after the faulty trial, the run ends early, ends late or lands on the wrong code. A corrupted table entry shows at once on `tbl_rd_data`, and in the next search as the wrong `eq_code`. An error in the no-lock path shows as `fail` or as a code that is not the starting entry.

// File: rtl/eqz_pkg.sv
package eqz_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_LOCK,
      ST_EYE,
      ST_FINISH
   } srch_st_e;

   // Defaults are listed as one base-4 digit per nibble, written stage 0 first.
   function automatic logic [15:0] dflt_digits(input int unsigned i);
      logic [15:0] d;
      case (i)
         0:  d = 16'h0000;   1:  d = 16'h0001;   2:  d = 16'h0010;   3:  d = 16'h0100;
         4:  d = 16'h1000;   5:  d = 16'h0020;   6:  d = 16'h0002;   7:  d = 16'h2000;
         8:  d = 16'h0003;   9:  d = 16'h0030;   10: d = 16'h0300;   11: d = 16'h1001;
         12: d = 16'h1100;   13: d = 16'h3000;   14: d = 16'h1200;   15: d = 16'h2100;
         16: d = 16'h2020;   17: d = 16'h2002;   18: d = 16'h2200;   19: d = 16'h1012;
         20: d = 16'h1102;   21: d = 16'h2030;   22: d = 16'h2300;   23: d = 16'h3020;
         24: d = 16'h1113;   25: d = 16'h1131;   26: d = 16'h1221;   27: d = 16'h1311;
         28: d = 16'h3111;   29: d = 16'h2121;   30: d = 16'h2112;   31: d = 16'h2211;
         default: d = 16'h0000;
      endcase
      return d;
   endfunction

   // Packs the digits into the code: stage 0 goes to bits 7:6, stage 3 to bits 1:0.
   function automatic logic [7:0] dflt_code(input int unsigned i);
      logic [15:0] d;
      d = dflt_digits(i);
      return {d[13:12], d[9:8], d[5:4], d[1:0]};
   endfunction

endpackage

// File: rtl/eqz_cand_table.sv
module eqz_cand_table #(
   parameter int N_ENT  = 32,
   parameter int CODE_W = 8,
   localparam int IDX_W = $clog2(N_ENT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [CODE_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  ra_idx,
   output logic [CODE_W-1:0] ra_data,
   input  logic [IDX_W-1:0]  rb_idx,
   output logic [CODE_W-1:0] rb_data
);
   import eqz_pkg::*;

   logic [CODE_W-1:0] ent_q [N_ENT];

   initial begin
      assert (CODE_W == 8) else $error("eqz_cand_table: CODE_W must be 8");
      assert (N_ENT >= 2 && N_ENT <= 32 && (1 << IDX_W) == N_ENT)
         else $error("eqz_cand_table: N_ENT must be a power of two from 2 to 32");
   end

   for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      localparam logic [CODE_W-1:0] DEF = CODE_W'(dflt_code(e));
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        ent_q[e] <= DEF;
         else if (soft_rst) ent_q[e] <= DEF;
         else if (hit)      ent_q[e] <= wr_data;
      end

      // R2
      soft_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
         soft_rst |=> ent_q[e] == DEF);
   end

   assign ra_data = ent_q[ra_idx];
   assign rb_data = ent_q[rb_idx];
endmodule

// File: rtl/eqz_fom.sv
module eqz_fom #(
   parameter int EYE_W    = 6,
   parameter bit MODE_MIN = 1'b0,
   localparam int FOM_W   = EYE_W + 1
) (
   input  logic [EYE_W-1:0] eye_h,
   input  logic [EYE_W-1:0] eye_v,
   input  logic [FOM_W-1:0] best_fom,
   input  logic             best_vld,
   output logic [FOM_W-1:0] fom,
   output logic             better
);
   initial begin
      assert (EYE_W >= 2 && EYE_W <= 15) else $error("eqz_fom: EYE_W must be 2..15");
   end

   if (MODE_MIN) begin : g_min
      // Variant: twice the smaller opening, so the result spans the same range as the sum.
      logic [EYE_W-1:0] lo;
      assign lo  = (eye_h < eye_v) ? eye_h : eye_v;
      assign fom = {lo, 1'b0};
   end else begin : g_sum
      assign fom = {1'b0, eye_h} + {1'b0, eye_v};
   end

   assign better = !best_vld || (fom > best_fom);
endmodule

// File: rtl/eqz_search_fsm.sv
module eqz_search_fsm #(
   parameter int N_ENT  = 32,
   parameter int CODE_W = 8,
   parameter int EYE_W  = 6,
   parameter int LB_W   = 4,
   localparam int IDX_W = $clog2(N_ENT),
   localparam int FOM_W = EYE_W + 1,
   localparam int MS_W  = LB_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_ovr_en,
   input  logic [IDX_W-1:0]  start_ovr_idx,
   input  logic [LB_W-1:0]   look_beyond,
   output logic [IDX_W-1:0]  cur_idx,
   input  logic [CODE_W-1:0] cur_code,
   output logic              lock_req,
   input  logic              lock_ack,
   input  logic              lock_ok,
   output logic              eye_req,
   input  logic              eye_ack,
   input  logic [FOM_W-1:0]  fom,
   input  logic              better,
   output logic [FOM_W-1:0]  best_fom,
   output logic              best_vld,
   output logic [CODE_W-1:0] eq_code,
   output logic [CODE_W-1:0] best_code,
   output logic              busy,
   output logic              done,
   output logic              fail
);
   import eqz_pkg::*;

   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

   srch_st_e          st_q;
   logic [MS_W-1:0]   miss_q;
   logic [CODE_W-1:0] win_q;
   logic [CODE_W-1:0] first_q;
   logic              first_pend_q;

   logic              trial_end, trial_good, stop;
   logic [MS_W-1:0]   miss_inc;

   assign lock_req   = (st_q == ST_LOCK);
   assign eye_req    = (st_q == ST_EYE);
   assign trial_end  = (lock_req && lock_ack && !lock_ok) || (eye_req && eye_ack);
   assign trial_good = eye_req && eye_ack && better;
   assign miss_inc   = miss_q + MS_W'(1);
   assign stop       = (!trial_good && (miss_inc > {1'b0, look_beyond})) || (cur_idx == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         cur_idx      <= '0;
         miss_q       <= '0;
         best_fom     <= '0;
         best_vld     <= 1'b0;
         win_q        <= '0;
         first_q      <= '0;
         first_pend_q <= 1'b0;
         eq_code      <= '0;
         best_code    <= '0;
         busy         <= 1'b0;
         done         <= 1'b0;
         fail         <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  cur_idx      <= start_ovr_en ? start_ovr_idx : '0;
                  miss_q       <= '0;
                  best_vld     <= 1'b0;
                  first_pend_q <= 1'b1;
                  busy         <= 1'b1;
                  done         <= 1'b0;
                  fail         <= 1'b0;
                  st_q         <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               eq_code <= cur_code;
               if (first_pend_q) first_q <= cur_code;
               first_pend_q <= 1'b0;
               st_q         <= ST_LOCK;
            end
            ST_LOCK: begin
               if (lock_ack && lock_ok) st_q <= ST_EYE;
            end
            ST_EYE: ;
            ST_FINISH: begin
               eq_code   <= best_vld ? win_q : first_q;
               best_code <= best_vld ? win_q : first_q;
               fail      <= !best_vld;
               busy      <= 1'b0;
               done      <= 1'b1;
               st_q      <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase

         if (trial_end) begin
            if (trial_good) begin
               best_vld <= 1'b1;
               best_fom <= fom;
               win_q    <= eq_code;
               miss_q   <= '0;
            end else begin
               miss_q   <= miss_inc;
            end
            if (stop) begin
               st_q <= ST_FINISH;
            end else begin
               cur_idx <= cur_idx + IDX_W'(1);
               st_q    <= ST_SETTLE;
            end
         end
      end
   end

   // R5
   req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lock_req && eye_req));
   // R5
   eye_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eye_req) |-> $past(lock_ack && lock_ok));
   // R12
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((lock_req || eye_req) && $past(lock_req || eye_req)) |-> $stable(eq_code));
   // R10
   busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));
   // R10
   fell_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done && eq_code == best_code));
   // R9
   last_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trial_end && cur_idx == LAST) |=> st_q == ST_FINISH);
endmodule

// File: rtl/eqz_boost_adapt.sv
module eqz_boost_adapt #(
   parameter int N_ENT    = 32,
   parameter int CODE_W   = 8,
   parameter int EYE_W    = 6,
   parameter int LB_W     = 4,
   parameter int LB_RST   = 2,
   parameter bit FOM_MIN  = 1'b0,
   localparam int IDX_W   = $clog2(N_ENT),
   localparam int FOM_W   = EYE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              tbl_wr_en,
   input  logic [IDX_W-1:0]  tbl_wr_idx,
   input  logic [CODE_W-1:0] tbl_wr_data,
   input  logic [IDX_W-1:0]  tbl_rd_idx,
   output logic [CODE_W-1:0] tbl_rd_data,
   input  logic              lb_wr_en,
   input  logic [LB_W-1:0]   lb_wr_data,
   input  logic              start_ovr_en,
   input  logic [IDX_W-1:0]  start_ovr_idx,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic [CODE_W-1:0] eq_code,
   output logic [CODE_W-1:0] best_code,
   output logic              lock_req,
   input  logic              lock_ack,
   input  logic              lock_ok,
   output logic              eye_req,
   input  logic              eye_ack,
   input  logic [EYE_W-1:0]  eye_h,
   input  logic [EYE_W-1:0]  eye_v
);
   initial begin
      assert (LB_RST >= 0 && LB_RST < (1 << LB_W))
         else $error("eqz_boost_adapt: LB_RST does not fit in LB_W bits");
   end

   logic [LB_W-1:0]   lb_q;
   logic [IDX_W-1:0]  cur_idx;
   logic [CODE_W-1:0] cur_code;
   logic [FOM_W-1:0]  fom, best_fom;
   logic              better, best_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lb_q <= LB_W'(LB_RST);
      else if (lb_wr_en) lb_q <= lb_wr_data;
   end

   // R8
   lb_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lb_wr_en |=> lb_q == $past(lb_wr_data));

   eqz_cand_table #(.N_ENT(N_ENT), .CODE_W(CODE_W)) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_rst(soft_rst),
      .wr_en   (tbl_wr_en),
      .wr_idx  (tbl_wr_idx),
      .wr_data (tbl_wr_data),
      .ra_idx  (cur_idx),
      .ra_data (cur_code),
      .rb_idx  (tbl_rd_idx),
      .rb_data (tbl_rd_data)
   );

   eqz_fom #(.EYE_W(EYE_W), .MODE_MIN(FOM_MIN)) u_fom (
      .eye_h   (eye_h),
      .eye_v   (eye_v),
      .best_fom(best_fom),
      .best_vld(best_vld),
      .fom     (fom),
      .better  (better)
   );

   eqz_search_fsm #(.N_ENT(N_ENT), .CODE_W(CODE_W), .EYE_W(EYE_W), .LB_W(LB_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .start_ovr_en (start_ovr_en),
      .start_ovr_idx(start_ovr_idx),
      .look_beyond  (lb_q),
      .cur_idx      (cur_idx),
      .cur_code     (cur_code),
      .lock_req     (lock_req),
      .lock_ack     (lock_ack),
      .lock_ok      (lock_ok),
      .eye_req      (eye_req),
      .eye_ack      (eye_ack),
      .fom          (fom),
      .better       (better),
      .best_fom     (best_fom),
      .best_vld     (best_vld),
      .eq_code      (eq_code),
      .best_code    (best_code),
      .busy         (busy),
      .done         (done),
      .fail         (fail)
   );
endmodule

// File: tb/eqz_boost_adapt_bench.sv
module eqz_boost_adapt_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0, tbl_wr_en = 1'b0, lb_wr_en = 1'b0;
   logic [4:0] tbl_wr_idx = '0, tbl_rd_idx = '0, start_ovr_idx = '0;
   logic [7:0] tbl_wr_data = '0, tbl_rd_data;
   logic [3:0] lb_wr_data = '0;
   logic       start_ovr_en = 1'b0, start = 1'b0;
   logic       busy, done, fail, lock_req, eye_req;
   logic [7:0] eq_code, best_code;
   logic       lock_ack = 1'b0, lock_ok = 1'b0, eye_ack = 1'b0;
   logic [5:0] eye_h = '0, eye_v = '0;

   always #2 clk = ~clk;

   eqz_boost_adapt u_eqz_boost_adapt (.*);

   int   n_chk = 0, n_bad = 0, n_trials = 0;
   bit   finished = 0;
   logic [7:0] mir [32];
   bit   lk_map [256];
   int   h_map [256], v_map [256];
   int   cur_lb = 2;

   function automatic logic [7:0] def_code(int i);
      case (i)
         0: return 8'h00;  1: return 8'h01;  2: return 8'h04;  3: return 8'h10;
         4: return 8'h40;  5: return 8'h08;  6: return 8'h02;  7: return 8'h80;
         8: return 8'h03;  9: return 8'h0C; 10: return 8'h30; 11: return 8'h41;
        12: return 8'h50; 13: return 8'hC0; 14: return 8'h60; 15: return 8'h90;
        16: return 8'h88; 17: return 8'h82; 18: return 8'hA0; 19: return 8'h46;
        20: return 8'h52; 21: return 8'h8C; 22: return 8'hB0; 23: return 8'hC8;
        24: return 8'h57; 25: return 8'h5D; 26: return 8'h69; 27: return 8'h75;
        28: return 8'hD5; 29: return 8'h99; 30: return 8'h96; default: return 8'hA5;
      endcase
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Responder for the lock detector and the eye monitor; it also counts lock request rises.
   initial begin
      bit prev_l = 0;
      int wait_l = 0, wait_e = 0;
      forever begin
         @(negedge clk);
         lock_ack = 1'b0; eye_ack = 1'b0;
         if (lock_req && !prev_l) n_trials++;
         prev_l = lock_req;
         if (lock_req) begin
            if (wait_l == 0) begin
               lock_ack = 1'b1; lock_ok = lk_map[eq_code]; wait_l = $urandom % 3;
            end else wait_l--;
         end
         if (eye_req) begin
            if (wait_e == 0) begin
               eye_ack = 1'b1; eye_h = 6'(h_map[eq_code]); eye_v = 6'(v_map[eq_code]);
               wait_e = $urandom % 4;
            end else wait_e--;
         end
      end
   end

   task automatic run(string tag, bit ovr, int sidx, bit wr_lb, int lb);
      int idx, miss, trials, best, fv;
      bit bv;
      logic [7:0] win, exp_code;
      if (wr_lb) begin
         lb_wr_en = 1'b1; lb_wr_data = 4'(lb); @(negedge clk); lb_wr_en = 1'b0;
         cur_lb = lb;
      end
      start_ovr_en = ovr; start_ovr_idx = 5'(sidx);
      idx = ovr ? sidx : 0; miss = 0; trials = 0; bv = 0; best = 0; win = 0;
      forever begin
         trials++;
         fv = h_map[mir[idx]] + v_map[mir[idx]];
         if (lk_map[mir[idx]] && (!bv || fv > best)) begin
            bv = 1; best = fv; win = mir[idx]; miss = 0;
         end else miss++;
         if (miss > cur_lb || idx == 31) break;
         idx++;
      end
      exp_code = bv ? win : mir[ovr ? sidx : 0];
      n_trials = 0;
      start = 1'b1; @(negedge clk); start = 1'b0;
      @(negedge clk);
      chk(busy === 1'b1, "R4", {tag, " busy after start"}, int'(busy), 1);
      while (done !== 1'b1) @(negedge clk);
      chk(best_code === exp_code, "R6", {tag, " best_code"}, int'(best_code), int'(exp_code));
      chk(eq_code === exp_code, "R10", {tag, " eq_code"}, int'(eq_code), int'(exp_code));
      chk(busy === 1'b0, "R10", {tag, " busy low at done"}, int'(busy), 0);
      chk(fail === !bv, "R11", {tag, " fail"}, int'(fail), int'(!bv));
      chk(n_trials == trials, "R7", {tag, " trial count"}, n_trials, trials);
   endtask

   task automatic rand_maps(int pct);
      for (int c = 0; c < 256; c++) begin
         lk_map[c] = ($urandom % 100) < pct;
         h_map[c] = $urandom % 64;
         v_map[c] = $urandom % 64;
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 32; i++) mir[i] = def_code(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: default table after power-on reset, and idle outputs
      for (int i = 0; i < 32; i++) begin
         tbl_rd_idx = 5'(i); #1;
         chk(tbl_rd_data === def_code(i), "R1", "default entry", int'(tbl_rd_data), int'(def_code(i)));
      end
      chk(busy === 1'b0 && done === 1'b0 && lock_req === 1'b0, "R1", "idle after reset",
          int'({busy, done, lock_req}), 0);

      // R8: reset look-beyond of 2: entry 0 locks and scores, entries 1..3 fail lock -> 4 trials
      for (int c = 0; c < 256; c++) begin lk_map[c] = 0; h_map[c] = 1; v_map[c] = 1; end
      lk_map[8'h00] = 1;
      run("R8 reset lb", 1'b0, 0, 1'b0, 0);

      // R11: nothing locks, override start at 20
      for (int c = 0; c < 256; c++) lk_map[c] = 0;
      run("R11 no lock", 1'b1, 20, 1'b1, 3);

      // R9: rising FOM along the table reaches index 31
      for (int i = 0; i < 32; i++) begin
         lk_map[mir[i]] = 1; h_map[mir[i]] = i; v_map[mir[i]] = i;
      end
      run("R9 climb", 1'b1, 5, 1'b1, 1);
      run("R9 start31", 1'b1, 31, 1'b1, 4);

      // R7: zero look-beyond and maximum look-beyond
      rand_maps(70);
      run("R7 lb0", 1'b0, 0, 1'b1, 0);
      run("R7 lb15", 1'b0, 0, 1'b1, 15);

      // R6: equal FOM does not replace the best
      for (int c = 0; c < 256; c++) begin lk_map[c] = 1; h_map[c] = 10; v_map[c] = 10; end
      run("R6 ties", 1'b1, 3, 1'b1, 2);

      // R3: rewrite entries, then search with random maps
      for (int k = 0; k < 20; k++) begin
         int n = $urandom % 4;
         for (int w = 0; w < n; w++) begin
            int wi = $urandom % 32;
            logic [7:0] wd = 8'($urandom);
            tbl_wr_en = 1'b1; tbl_wr_idx = 5'(wi); tbl_wr_data = wd;
            @(negedge clk);
            tbl_wr_en = 1'b0; mir[wi] = wd;
            tbl_rd_idx = 5'(wi); #1;
            chk(tbl_rd_data === wd, "R3", "written entry", int'(tbl_rd_data), int'(wd));
         end
         rand_maps(40 + ($urandom % 60));
         run("R3 random", ($urandom % 2) == 1, $urandom % 32, 1'b1, $urandom % 16);
      end

      // R2: soft reset with a simultaneous write restores defaults
      tbl_wr_en = 1'b1; tbl_wr_idx = 5'd7; tbl_wr_data = 8'h3C; soft_rst = 1'b1;
      @(negedge clk);
      tbl_wr_en = 1'b0; soft_rst = 1'b0;
      for (int i = 0; i < 32; i++) begin
         mir[i] = def_code(i);
         tbl_rd_idx = 5'(i); #1;
         chk(tbl_rd_data === def_code(i), "R2", "entry after soft reset", int'(tbl_rd_data), int'(def_code(i)));
      end
      rand_maps(80);
      run("R2 after soft", 1'b0, 0, 1'b1, 2);

      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule